// File: doc/BRIEF.md
# Compare-Triggered Capture Core

This core is an on-chip logic analyzer. On every clock it records a probed data word into a circular sample buffer. In the same cycle it records a separate trigger word into a second buffer at the same slot. It watches the trigger word for a runtime-programmed condition: the word, ANDed with a mask, must equal a reference value. A mask of all ones gives plain equality. A single-bit trigger is made by tying the unused trigger bits to a constant and masking them off.

After the first qualifying event, the core keeps writing for a programmed number of samples (the holdoff), then freezes. Software can then read the whole window back, oldest sample first, over a small 32-bit register bus. Software can also force the event, and it can rearm the core with a fresh holdoff while the core runs. Each stored trigger word sits beside its data sample, so the values around the event can be seen.

Top module: `lacap_core`

## Requirements
- R1: After reset the core is armed, not triggered and not stopped, so the status word reads 0x0000_0004. The reference resets to all ones and the mask to zero, so no compare event can occur until software programs them.
- R2: While not stopped, both buffers are written every cycle at one shared write slot. The slot steps by one and wraps from DEPTH-1 to 0.
- R3: An event is detected when (trigger & mask) == reference. With the mask at all ones, a word that differs from the reference in one bit never fires.
- R4: The trigger word stored in a slot is the one presented in the same cycle as the data sample stored in that slot.
- R5: After the sample on which the event is detected, exactly HOLD further samples are stored, then writing stops. With HOLD = 0 the event sample is the newest entry.
- R6: Once stopped, neither buffer changes. The status word carries bit 0 = stopped, bit 1 = triggered, bit 2 = armed, and bits [31:16] = the stop slot. The stop slot is the next write slot, which holds the oldest sample.
- R7: Writing 1 to bit 1 of the control word at offset 0 forces the event while armed, whatever the compare result.
- R8: Writing 1 to bit 0 of the control word rearms the core. It clears the write slot, the read index and the stop slot to 0. The holdoff at offset 12 may be written at any time and is used at the next event.
- R9: Register offsets: 0 control/status, 4 reference, 8 mask, 12 holdoff, 16 data window, 20 trigger window. Read data is valid one cycle after the read strobe. A read at 16 returns the data at the read index, zero-extended, and advances the index with wrap. A read at 20 returns the trigger word at the read index and does not advance it. On stop, the read index is set to the stop slot.
- R10: Only the first event after arming counts. Further matches during holdoff or after stop have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| probe_data | input | DATA_W | Probed data word |
| probe_trig | input | TRIG_W | Trigger word compared and stored |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | High the cycle after a read strobe |

## Verification
The bench builds the core with DEPTH = 16, DATA_W = 16, TRIG_W = 32 and HOLD_W = 8. A 16-slot buffer wraps within a few dozen cycles, so the bench reaches wrap-around, holdoff at both extremes (0 and DEPTH-2) and window-index wrap on every run. The probed data is a running cycle count, so each stored sample names its own capture cycle. From this the bench can place the event sample and the holdoff tail without modelling the pipeline, and it can pair every stored trigger word with the one it drove in that cycle.

// File: rtl/lacap_pkg.sv
package lacap_pkg;

  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_POST  = 2'd1,
    ST_STOP  = 2'd2
  } cap_state_e;

  localparam logic [4:0] OFS_CTRL = 5'd0;
  localparam logic [4:0] OFS_REF  = 5'd4;
  localparam logic [4:0] OFS_MASK = 5'd8;
  localparam logic [4:0] OFS_HOLD = 5'd12;
  localparam logic [4:0] OFS_WIN  = 5'd16;
  localparam logic [4:0] OFS_TWIN = 5'd20;

  // masked equality test applied to the trigger word
  function automatic logic word_hit(input logic [31:0] w, input logic [31:0] m,
                                    input logic [31:0] r);
    return (w & m) == r;
  endfunction

  // status word layout
  function automatic logic [31:0] pack_status(input logic [15:0] sptr, input logic armed,
                                              input logic trig, input logic stopped);
    return {sptr, 13'd0, armed, trig, stopped};
  endfunction

endpackage

// File: rtl/lacap_mem.sv
module lacap_mem #(
  parameter int W     = 16,
  parameter int DEPTH = 1024,
  parameter int PTR_W = 10
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [W-1:0]     wdata,
  input  logic [PTR_W-1:0] raddr,
  output logic [W-1:0]     rdata
);
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/lacap_trig.sv
module lacap_trig
  import lacap_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TRIG_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] probe_data,
  input  logic [TRIG_W-1:0] probe_trig,
  input  logic [TRIG_W-1:0] ref_q,
  input  logic [TRIG_W-1:0] mask_q,
  output logic [DATA_W-1:0] d_q,
  output logic [TRIG_W-1:0] t_q,
  output logic              hit_q
);
  // data, trigger word and compare result share one register stage,
  // so the stored trigger word belongs to the same cycle as the data
  always_ff @(posedge clk) begin
    if (rst) begin
      d_q   <= '0;
      t_q   <= '0;
      hit_q <= 1'b0;
    end else begin
      d_q   <= probe_data;
      t_q   <= probe_trig;
      hit_q <= word_hit(32'(probe_trig), 32'(mask_q), 32'(ref_q));
    end
  end

  assert_hit_align_R4: assert property (@(posedge clk) disable iff (rst)
    hit_q == word_hit(32'(t_q), 32'($past(mask_q)), 32'($past(ref_q))));
endmodule

// File: rtl/lacap_regs.sv
module lacap_regs
  import lacap_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TRIG_W = 32,
  parameter int PTR_W  = 10,
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [4:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              st_stopped,
  input  logic              st_trig,
  input  logic              st_armed,
  input  logic [PTR_W-1:0]  stop_ptr,
  input  logic [DATA_W-1:0] win_data,
  input  logic [TRIG_W-1:0] win_trig,
  output logic [TRIG_W-1:0] ref_q,
  output logic [TRIG_W-1:0] mask_q,
  output logic [HOLD_W-1:0] hold_q,
  output logic              rearm_p,
  output logic              force_p,
  output logic              win_pop,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid
);
  logic wr_ctrl;
  logic [15:0] sptr_ext;

  assign wr_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
  assign win_pop  = bus_rd && (bus_addr == OFS_WIN);
  assign sptr_ext = 16'(stop_ptr);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q   <= '1;
      mask_q  <= '0;
      hold_q  <= '0;
      rearm_p <= 1'b0;
      force_p <= 1'b0;
    end else begin
      rearm_p <= wr_ctrl && bus_wdata[0];
      force_p <= wr_ctrl && bus_wdata[1];
      if (bus_wr && bus_addr == OFS_REF)  ref_q  <= bus_wdata[TRIG_W-1:0];
      if (bus_wr && bus_addr == OFS_MASK) mask_q <= bus_wdata[TRIG_W-1:0];
      if (bus_wr && bus_addr == OFS_HOLD) hold_q <= bus_wdata[HOLD_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        case (bus_addr)
          OFS_CTRL: bus_rdata <= pack_status(sptr_ext, st_armed, st_trig, st_stopped);
          OFS_REF:  bus_rdata <= 32'(ref_q);
          OFS_MASK: bus_rdata <= 32'(mask_q);
          OFS_HOLD: bus_rdata <= 32'(hold_q);
          OFS_WIN:  bus_rdata <= 32'(win_data);
          OFS_TWIN: bus_rdata <= 32'(win_trig);
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end

  assert_rvalid_R9: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
  assert_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rearm_p |=> !rearm_p || $past(wr_ctrl));
endmodule

// File: rtl/lacap_ctrl.sv
module lacap_ctrl
  import lacap_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int PTR_W  = 10,
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic              force_p,
  input  logic              rearm_p,
  input  logic [HOLD_W-1:0] hold,
  input  logic              win_pop,
  output logic              we,
  output logic [PTR_W-1:0]  wptr,
  output logic [PTR_W-1:0]  rd_idx,
  output logic [PTR_W-1:0]  stop_ptr,
  output logic              st_armed,
  output logic              st_trig,
  output logic              st_stopped
);
  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  cap_state_e        st;
  logic [HOLD_W-1:0] cnt;
  logic              fire;
  logic [PTR_W-1:0]  wnext;

  assign fire  = hit || force_p;
  assign wnext = ptr_next(wptr);
  assign we    = (st != ST_STOP);

  assign st_armed   = (st == ST_ARMED);
  assign st_trig    = (st != ST_ARMED);
  assign st_stopped = (st == ST_STOP);

  always_ff @(posedge clk) begin
    if (rst || rearm_p) begin
      st       <= ST_ARMED;
      wptr     <= '0;
      cnt      <= '0;
      rd_idx   <= '0;
      stop_ptr <= '0;
    end else begin
      if (win_pop) rd_idx <= ptr_next(rd_idx);
      case (st)
        ST_ARMED: begin
          wptr <= wnext;
          if (fire) begin
            if (hold == '0) begin
              st       <= ST_STOP;
              stop_ptr <= wnext;
              rd_idx   <= wnext;
            end else begin
              st  <= ST_POST;
              cnt <= hold;
            end
          end
        end
        ST_POST: begin
          wptr <= wnext;
          if (cnt == HOLD_W'(1)) begin
            st       <= ST_STOP;
            stop_ptr <= wnext;
            rd_idx   <= wnext;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assert_ptr_step_R2: assert property (@(posedge clk) disable iff (rst)
    (we && !rearm_p) |=> wptr == ptr_next($past(wptr)));
  assert_wait_R3: assert property (@(posedge clk) disable iff (rst)
    (st_armed && !fire && !rearm_p) |=> st_armed);
  assert_count_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_POST && cnt != HOLD_W'(1) && !rearm_p) |=> (st == ST_POST && cnt == $past(cnt) - 1'b1));
  assert_stop_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_POST && cnt == HOLD_W'(1) && !rearm_p) |=> (st_stopped && stop_ptr == wptr));
  assert_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    (st_stopped && !rearm_p) |=> (st_stopped && $stable(wptr)));
  assert_first_only_R10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_POST && !rearm_p) |=> st != ST_ARMED);
endmodule

// File: rtl/lacap_core.sv
module lacap_core #(
  parameter int DATA_W = 16,
  parameter int TRIG_W = 32,
  parameter int DEPTH  = 1024,
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] probe_data,
  input  logic [TRIG_W-1:0] probe_trig,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [4:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] d_q, win_data;
  logic [TRIG_W-1:0] t_q, win_trig, ref_q, mask_q;
  logic [HOLD_W-1:0] hold_q;
  logic              hit_q, rearm_p, force_p, win_pop, we;
  logic              st_armed, st_trig, st_stopped;
  logic [PTR_W-1:0]  wptr, rd_idx, stop_ptr;

  lacap_trig #(.DATA_W(DATA_W), .TRIG_W(TRIG_W)) u_trig (
    .clk(clk), .rst(rst), .probe_data(probe_data), .probe_trig(probe_trig),
    .ref_q(ref_q), .mask_q(mask_q), .d_q(d_q), .t_q(t_q), .hit_q(hit_q)
  );

  lacap_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .HOLD_W(HOLD_W)) u_ctrl (
    .clk(clk), .rst(rst), .hit(hit_q), .force_p(force_p), .rearm_p(rearm_p),
    .hold(hold_q), .win_pop(win_pop), .we(we), .wptr(wptr), .rd_idx(rd_idx),
    .stop_ptr(stop_ptr), .st_armed(st_armed), .st_trig(st_trig),
    .st_stopped(st_stopped)
  );

  lacap_mem #(.W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_dmem (
    .clk(clk), .we(we), .waddr(wptr), .wdata(d_q), .raddr(rd_idx), .rdata(win_data)
  );

  lacap_mem #(.W(TRIG_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_tmem (
    .clk(clk), .we(we), .waddr(wptr), .wdata(t_q), .raddr(rd_idx), .rdata(win_trig)
  );

  lacap_regs #(.DATA_W(DATA_W), .TRIG_W(TRIG_W), .PTR_W(PTR_W), .HOLD_W(HOLD_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .st_stopped(st_stopped), .st_trig(st_trig),
    .st_armed(st_armed), .stop_ptr(stop_ptr), .win_data(win_data),
    .win_trig(win_trig), .ref_q(ref_q), .mask_q(mask_q), .hold_q(hold_q),
    .rearm_p(rearm_p), .force_p(force_p), .win_pop(win_pop),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );
endmodule

// File: tb/sim_lacap_core.sv
module sim_lacap_core;
  localparam int DATA_W = 16;
  localparam int TRIG_W = 32;
  localparam int DEPTH  = 16;
  localparam int HOLD_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DATA_W-1:0] probe_data = '0;
  logic [TRIG_W-1:0] probe_trig = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid;

  int errors = 0;
  int checks = 0;
  int unsigned cyc = 0;
  logic [31:0] hist [256];
  int mode = 0;
  logic [31:0] m_b = '0, r_b = '1;
  bit match_seen = 1'b0;
  logic [15:0] match_cyc = '0;

  always #5 clk = ~clk;

  lacap_core #(.DATA_W(DATA_W), .TRIG_W(TRIG_W), .DEPTH(DEPTH), .HOLD_W(HOLD_W)) u0 (
    .clk(clk), .rst(rst), .probe_data(probe_data), .probe_trig(probe_trig),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  // bench form of the match: bits under the mask agree with the reference
  function automatic bit bench_match(input logic [31:0] w, input logic [31:0] m,
                                     input logic [31:0] r);
    return ((w ^ r) & m) == 32'd0;
  endfunction

  function automatic logic [31:0] gen_word(input int md);
    logic [31:0] w;
    w = $urandom;
    if (md == 1) w = (w & ~m_b) | r_b;
    else if (md == 2) w = r_b ^ (32'd1 << ($urandom % 32));
    else if (bench_match(w, m_b, r_b)) w = w ^ (m_b & (~m_b + 32'd1));
    return w;
  endfunction

  // probe driver: data is the running cycle count
  initial begin
    forever begin
      @(negedge clk);
      begin
        logic [31:0] w;
        w = gen_word(mode);
        probe_data = cyc[15:0];
        probe_trig = w;
        hist[cyc[7:0]] = w;
        if (mode == 1 && !match_seen) begin
          match_seen = 1'b1;
          match_cyc = cyc[15:0];
        end
        cyc++;
      end
    end
  end

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // read the whole window, oldest first, checking data continuity and pairing
  task automatic read_window(input bit know_first, input logic [15:0] first, input string tag);
    logic [31:0] d, t;
    logic [15:0] base;
    for (int i = 0; i < DEPTH; i++) begin
      bread(5'd20, t);
      bread(5'd16, d);
      if (i == 0 && !know_first) base = d[15:0];
      else if (i == 0) base = first;
      chk(d, 32'(base + 16'(i)), {tag, " R2 R5 data order"});
      chk(t, hist[8'(base + 16'(i))], {tag, " R4 trigger pairing"});
    end
    bread(5'd16, d);
    chk(d, 32'(base), {tag, " R9 window wrap"});
  endtask

  task automatic run_match(input int h, input logic [31:0] m, input logic [31:0] r,
                           input string tag);
    logic [31:0] s, d0, d1;
    m_b = m; r_b = r & m; mode = 0;
    bwrite(5'd4, r_b);
    bwrite(5'd8, m_b);
    bwrite(5'd12, 32'(h));
    bwrite(5'd0, 32'h1);
    bread(5'd0, s);
    chk(s, 32'h4, {tag, " R8 rearm status"});
    wait_cyc(40);
    bread(5'd0, s);
    chk(s, 32'h4, {tag, " R3 no event on mismatching words"});
    match_seen = 1'b0;
    mode = 1;
    wait_cyc(30);
    mode = 0;
    bread(5'd0, s);
    chk(s[2:0], 3'b011, {tag, " R6 stopped and triggered"});
    // R5/R10: event sample sits HOLD entries before the newest one
    read_window(1'b1, match_cyc - 16'(DEPTH - 1 - h), tag);
    bread(5'd16, d0);
    wait_cyc(20);
    bwrite(5'd0, 32'h0);
    bread(5'd20, d1);
    chk(d1, hist[8'(match_cyc - 16'(DEPTH - 1 - h) + 16'd2)], {tag, " R6 frozen after stop"});
  endtask

  initial begin
    logic [31:0] s;
    void'($urandom(32'h5eed_1234));
    rst = 1'b1;
    wait_cyc(4);
    rst = 1'b0;
    bread(5'd0, s);
    chk(s, 32'h4, "R1 status after reset");
    bread(5'd4, s);
    chk(s, 32'hffff_ffff, "R1 reference reset");
    bread(5'd8, s);
    chk(s, 32'h0, "R1 mask reset");
    mode = 0;
    wait_cyc(30);
    bread(5'd0, s);
    chk(s, 32'h4, "R1 no event before programming");

    for (int k = 0; k < 4; k++) begin
      logic [31:0] m;
      m = $urandom | 32'h1;
      run_match(1 + ($urandom % 10), m, $urandom, "rand");
    end
    run_match(0, 32'hffff_ffff, $urandom, "R5 hold zero");
    run_match(DEPTH - 2, 32'h0000_00ff, 32'h5a, "R5 hold max");

    // all-ones mask, near misses, then forced event
    m_b = 32'hffff_ffff; r_b = $urandom;
    bwrite(5'd4, r_b);
    bwrite(5'd8, m_b);
    bwrite(5'd12, 32'd3);
    bwrite(5'd0, 32'h1);
    mode = 2;
    wait_cyc(40);
    bread(5'd0, s);
    chk(s, 32'h4, "R3 one-bit near miss ignored");
    bwrite(5'd0, 32'h2);
    wait_cyc(10);
    bread(5'd0, s);
    chk(s[2:0], 3'b011, "R7 forced event stops core");
    read_window(1'b0, 16'd0, "R7 forced");
    mode = 0;
    bwrite(5'd0, 32'h1);
    bread(5'd0, s);
    chk(s, 32'h4, "R8 rearm clears stop slot");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule